// File: doc/BRIEF.md
# Trace Ring Capture Buffer

This block records a stream of trace words into an on-chip RAM that is used as a ring. Incoming words pass through a short input pipeline and are written at the write pointer, which advances and wraps around the ring. Capture does not stop when the ring fills. It keeps overwriting the oldest words until a trigger has been seen and a programmed number of further words have been stored. Once that post-trigger budget runs out, storing stops, so the ring holds the history leading up to the trigger and a chosen amount of what followed.

Software drives the block through a small register bus. Before a capture it loads the post-trigger word budget (typically depth times a percentage between 2 and 100, divided by 100), clears the write pointer and sets the enable bit. It then polls the status register. Acquisition complete can show up while words are still in the input pipeline, so a reader waits for the drained flag before it unloads. To unload, software sets the read pointer to the oldest valid entry and reads the data register repeatedly. If the full flag is clear, that entry is 0. If it is set, the entry is the write pointer.

DEPTH must be a power of two. PIPE_STAGES sets the input pipeline length: a word presented on the input is stored at the clock edge PIPE_STAGES+1 edges later.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset the control register, write pointer, read pointer and trigger counter read 0, and status reads 0x8 (only drained set).
- R2: Register offsets are 0 control, 1 status, 2 write pointer, 3 read pointer, 4 trigger counter, 5 RAM data, 6 identification, 7 depth, 8 width. Identification returns ID_VALUE, depth returns DEPTH, and width returns WIDTH.
- R3: While control bit 0 is set, each valid input word is stored at the write pointer, and the pointer then advances modulo DEPTH. Words that arrive while bit 0 is clear are dropped.
- R4: Status bit 0 (full) sets when a store wraps the write pointer from DEPTH-1 to 0. It stays set until capture is restarted.
- R5: Status bit 1 (triggered) sets when a trigger pulse reaches the store stage while capture is enabled. A further trigger after that is ignored and does not change the countdown.
- R6: After the trigger, each stored word decrements the trigger counter. The word that carries the trigger does not count. When the counter is 0 and triggered is set, status bit 2 (acquisition complete) sets and no further words are stored.
- R7: Status bit 3 (drained) is 1 exactly when no word or trigger is in the input pipeline. Bit 2 may read 1 while bit 3 still reads 0.
- R8: A read of the RAM data register returns the word at the read pointer, zero-extended to 32 bits. The read pointer then advances modulo DEPTH.
- R9: Writes to the write pointer, read pointer and trigger counter registers load them directly, and reads return the current value.
- R10: Control bit 0 enables capture and bit 1 selects demultiplexed mode. Both read back. A control write that sets bit 0 while it was clear clears status bits 0 to 2. The pointers are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trc_valid_i | input | 1 | Trace word valid |
| trc_data_i | input | WIDTH | Trace word |
| trc_trig_i | input | 1 | Trigger pulse, travels with the input pipeline |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (advances read pointer on data reads) |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the offset |

## Verification
The bench goes after the wrap case. It stores 25 words into a 16-entry ring with triggers on words 20 and 22. A design that counted the trigger word, or re-armed on the second trigger, would stop at the wrong point and return a shifted sequence when unloaded from the write pointer. A design that failed to wrap would leave full clear or read stale entries. Two more corner cases are covered: a zero post-trigger budget, where a design that tested the counter too late would store one extra word, and a status read taken while the last words are still in the pipeline, where a design that tied drained to acquisition complete would show 0xF instead of 0x7. Dropped words while capture is disabled, pointer overrides near the ring end, and read-pointer wrap are each checked through the pointer and data registers.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam logic [3:0] ADDR_CTRL  = 4'd0;
  localparam logic [3:0] ADDR_STAT  = 4'd1;
  localparam logic [3:0] ADDR_WPTR  = 4'd2;
  localparam logic [3:0] ADDR_RPTR  = 4'd3;
  localparam logic [3:0] ADDR_TCNT  = 4'd4;
  localparam logic [3:0] ADDR_DATA  = 4'd5;
  localparam logic [3:0] ADDR_IDENT = 4'd6;
  localparam logic [3:0] ADDR_DEPTH = 4'd7;
  localparam logic [3:0] ADDR_WIDTH = 4'd8;

  typedef struct packed {
    logic drained;
    logic done;
    logic trig;
    logic full;
  } trc_stat_t;
endpackage

// File: rtl/trc_in_pipe.sv
module trc_in_pipe #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             trig_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic             trig_o,
  output logic             empty_o
);
  logic [STAGES-1:0] v_q, t_q;
  logic [WIDTH-1:0]  d_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q[0] <= 1'b0;
      t_q[0] <= 1'b0;
    end else begin
      v_q[0] <= valid_i & en_i;
      t_q[0] <= trig_i & en_i;
    end
  end

  always_ff @(posedge clk_i) d_q[0] <= data_i;

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[gi] <= 1'b0;
        t_q[gi] <= 1'b0;
      end else begin
        v_q[gi] <= v_q[gi-1];
        t_q[gi] <= t_q[gi-1];
      end
    end
    always_ff @(posedge clk_i) d_q[gi] <= d_q[gi-1];
  end

  assign valid_o = v_q[STAGES-1];
  assign trig_o  = t_q[STAGES-1];
  assign data_o  = d_q[STAGES-1];
  assign empty_o = ~(|v_q) & ~(|t_q);
endmodule

// File: rtl/trc_trig_ctl.sv
module trc_trig_ctl #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          in_valid_i,
  input  logic          in_trig_i,
  input  logic          tcnt_we_i,
  input  logic [CW-1:0] tcnt_wdata_i,
  output logic          store_o,
  output logic          trig_o,
  output logic          done_o,
  output logic [CW-1:0] tcnt_o
);
  logic          trig_q, done_q;
  logic [CW-1:0] tcnt_q;
  logic          budget_out;

  // budget spent: block the store stage before done registers
  assign budget_out = trig_q && (tcnt_q == '0);
  assign store_o    = en_i && in_valid_i && !done_q && !budget_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (en_i && in_trig_i && !done_q) trig_q <= 1'b1;
      if (budget_out) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tcnt_q <= '0;
    else if (tcnt_we_i)           tcnt_q <= tcnt_wdata_i;
    else if (store_o && trig_q)   tcnt_q <= tcnt_q - 1'b1;
  end

  assign trig_o = trig_q;
  assign done_o = done_q;
  assign tcnt_o = tcnt_q;
endmodule

// File: rtl/trc_ring.sv
module trc_ring #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             store_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             wptr_we_i,
  input  logic             rptr_we_i,
  input  logic [PW-1:0]    ptr_wdata_i,
  input  logic             rd_adv_i,
  output logic [PW-1:0]    wptr_o,
  output logic [PW-1:0]    rptr_o,
  output logic             full_o,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wptr_q, rptr_q;
  logic             full_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wptr_we_i)    wptr_q <= ptr_wdata_i;
      else if (store_i) wptr_q <= nxt(wptr_q);
      if (rptr_we_i)     rptr_q <= ptr_wdata_i;
      else if (rd_adv_i) rptr_q <= nxt(rptr_q);
      if (clr_i) full_q <= 1'b0;
      else if (store_i && !wptr_we_i && wptr_q == PW'(DEPTH - 1)) full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) if (store_i) mem_q[wptr_q] <= data_i;

  assign rdata_o = mem_q[rptr_q];
  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;
  assign full_o  = full_q;
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned PIPE_STAGES = 2,
  parameter logic [31:0] ID_VALUE    = 32'h5452_4301
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trc_valid_i,
  input  logic [WIDTH-1:0] trc_data_i,
  input  logic             trc_trig_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [3:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]       ctrl_q;
  logic             en, start, wptr_we, rptr_we, tcnt_we, rd_adv;
  logic             p_valid, p_trig, pipe_empty;
  logic [WIDTH-1:0] p_data, ram_rdata;
  logic             store, trig_flag, done, full;
  logic [31:0]      tcnt;
  logic [PW-1:0]    wptr, rptr;
  trc_stat_t        stat;

  assign en      = ctrl_q[0];
  assign start   = reg_we_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[0] && !ctrl_q[0];
  assign wptr_we = reg_we_i && reg_addr_i == ADDR_WPTR;
  assign rptr_we = reg_we_i && reg_addr_i == ADDR_RPTR;
  assign tcnt_we = reg_we_i && reg_addr_i == ADDR_TCNT;
  assign rd_adv  = reg_re_i && reg_addr_i == ADDR_DATA;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == ADDR_CTRL) ctrl_q <= reg_wdata_i[1:0];
  end

  trc_in_pipe #(.WIDTH(WIDTH), .STAGES(PIPE_STAGES)) u_pipe (
    .clk_i, .rst_ni, .en_i(en),
    .valid_i(trc_valid_i), .data_i(trc_data_i), .trig_i(trc_trig_i),
    .valid_o(p_valid), .data_o(p_data), .trig_o(p_trig), .empty_o(pipe_empty)
  );

  trc_trig_ctl #(.CW(32)) u_ctl (
    .clk_i, .rst_ni, .en_i(en), .start_i(start),
    .in_valid_i(p_valid), .in_trig_i(p_trig),
    .tcnt_we_i(tcnt_we), .tcnt_wdata_i(reg_wdata_i),
    .store_o(store), .trig_o(trig_flag), .done_o(done), .tcnt_o(tcnt)
  );

  trc_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ring (
    .clk_i, .rst_ni, .clr_i(start), .store_i(store), .data_i(p_data),
    .wptr_we_i(wptr_we), .rptr_we_i(rptr_we), .ptr_wdata_i(reg_wdata_i[PW-1:0]),
    .rd_adv_i(rd_adv), .wptr_o(wptr), .rptr_o(rptr), .full_o(full), .rdata_o(ram_rdata)
  );

  assign stat = '{drained: pipe_empty, done: done, trig: trig_flag, full: full};

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o = {30'd0, ctrl_q};
      ADDR_STAT:  reg_rdata_o = {28'd0, stat};
      ADDR_WPTR:  reg_rdata_o = 32'(wptr);
      ADDR_RPTR:  reg_rdata_o = 32'(rptr);
      ADDR_TCNT:  reg_rdata_o = tcnt;
      ADDR_DATA:  reg_rdata_o = 32'(ram_rdata);
      ADDR_IDENT: reg_rdata_o = ID_VALUE;
      ADDR_DEPTH: reg_rdata_o = 32'(DEPTH);
      ADDR_WIDTH: reg_rdata_o = 32'(WIDTH);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/trace_ring_buf_chk.sv
module trace_ring_buf_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en,
  input logic          start,
  input logic          store,
  input logic [PW-1:0] wptr,
  input logic          wptr_we,
  input logic          full,
  input logic          trig_flag,
  input logic          done,
  input logic [31:0]   tcnt,
  input logic          tcnt_we
);
  AST_WPTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store && !wptr_we |=> wptr == (($past(wptr) == PW'(DEPTH - 1)) ? '0 : $past(wptr) + 1'b1)); // R3
  AST_NO_STORE_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !store); // R3
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && !start |=> full); // R4
  AST_TRIG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_flag && !start |=> trig_flag); // R5
  AST_NO_STORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !store); // R6
  AST_TCNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_flag && store && !tcnt_we |=> tcnt == $past(tcnt) - 32'd1); // R6
  AST_DONE_AFTER_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> trig_flag); // R6
endmodule

bind trace_ring_buf trace_ring_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en(en), .start(start), .store(store),
  .wptr(wptr), .wptr_we(wptr_we), .full(full), .trig_flag(trig_flag),
  .done(done), .tcnt(tcnt), .tcnt_we(tcnt_we)
);

// File: tb/tb_trace_ring_buf.sv
module tb_trace_ring_buf;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned WIDTH = 20;
  localparam logic [31:0] ID    = 32'hC0DE_0016;

  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_WPTR = 4'd2, A_RPTR = 4'd3,
                         A_TCNT = 4'd4, A_DATA = 4'd5, A_IDENT = 4'd6, A_DEPTH = 4'd7,
                         A_WIDTH = 4'd8;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PU = 3'd2, OP_PT = 3'd3, OP_ID = 3'd4;
  localparam int NV = 32;
  // {op, addr, data, expected}
  localparam logic [70:0] VEC [NV] = '{
    {OP_WR, A_WPTR, 32'd0, 32'd0},   {OP_WR, A_TCNT, 32'd8, 32'd0},
    {OP_WR, A_CTRL, 32'd1, 32'd0},   {OP_PU, A_CTRL, 32'hA0, 32'd0},
    {OP_PU, A_CTRL, 32'hA1, 32'd0},  {OP_PU, A_CTRL, 32'hA2, 32'd0},
    {OP_ID, A_CTRL, 32'd4, 32'd0},   {OP_RD, A_STAT, 32'd0, 32'h8},
    {OP_RD, A_WPTR, 32'd0, 32'd3},   {OP_WR, A_RPTR, 32'd0, 32'd0},
    {OP_RD, A_DATA, 32'd0, 32'hA0},  {OP_RD, A_DATA, 32'd0, 32'hA1},
    {OP_RD, A_RPTR, 32'd0, 32'd2},   {OP_RD, A_DATA, 32'd0, 32'hA2},
    {OP_RD, A_RPTR, 32'd0, 32'd3},   {OP_WR, A_CTRL, 32'd3, 32'd0},
    {OP_RD, A_CTRL, 32'd0, 32'd3},   {OP_WR, A_CTRL, 32'd0, 32'd0},
    {OP_WR, A_TCNT, 32'd0, 32'd0},   {OP_WR, A_CTRL, 32'd1, 32'd0},
    {OP_PT, A_CTRL, 32'hB0, 32'd0},  {OP_PU, A_CTRL, 32'hB1, 32'd0},
    {OP_PU, A_CTRL, 32'hB2, 32'd0},  {OP_ID, A_CTRL, 32'd4, 32'd0},
    {OP_RD, A_STAT, 32'd0, 32'hE},   {OP_RD, A_WPTR, 32'd0, 32'd4},
    {OP_RD, A_TCNT, 32'd0, 32'd0},   {OP_WR, A_RPTR, 32'd3, 32'd0},
    {OP_RD, A_DATA, 32'd0, 32'hB0},  {OP_RD, A_IDENT, 32'd0, ID},
    {OP_RD, A_DEPTH, 32'd0, 32'd16}, {OP_RD, A_WIDTH, 32'd0, 32'd20}
  };

  logic             clk_i = 1'b0, rst_ni = 1'b0;
  logic             trc_valid_i = 1'b0, trc_trig_i = 1'b0;
  logic [WIDTH-1:0] trc_data_i = '0;
  logic             reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]       reg_addr_i = '0;
  logic [31:0]      reg_wdata_i = '0;
  logic [31:0]      reg_rdata_o;
  int               n_chk = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  trace_ring_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PIPE_STAGES(2), .ID_VALUE(ID)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    reg_re_i = 1'b1; reg_addr_i = a;
    #2 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic push(input logic [WIDTH-1:0] d, input logic t);
    trc_valid_i = 1'b1; trc_data_i = d; trc_trig_i = t;
    @(negedge clk_i);
    trc_valid_i = 1'b0; trc_trig_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  function automatic string req_of(input logic [3:0] a);
    case (a)
      A_CTRL:  return "R10";
      A_STAT:  return "R6 R7";
      A_WPTR:  return "R3";
      A_RPTR:  return "R8";
      A_TCNT:  return "R9";
      A_DATA:  return "R8";
      default: return "R2";
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // table walk: basic capture, readback, zero budget, constants (R2 R3 R8 R10)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][70:68])
        OP_WR: reg_wr(VEC[i][67:64], VEC[i][63:32]);
        OP_RD: begin
          reg_rd(VEC[i][67:64], v);
          chk(req_of(VEC[i][67:64]), v, VEC[i][31:0]);
        end
        OP_PU: push(VEC[i][WIDTH+31:32], 1'b0);
        OP_PT: push(VEC[i][WIDTH+31:32], 1'b1);
        default: repeat (VEC[i][63:32]) @(negedge clk_i);
      endcase
    end

    // R1 reset state
    do_reset();
    reg_rd(A_STAT, v); chk("R1", v, 32'h8);
    reg_rd(A_CTRL, v); chk("R1", v, 32'h0);
    reg_rd(A_WPTR, v); chk("R1", v, 32'h0);
    reg_rd(A_RPTR, v); chk("R1", v, 32'h0);
    reg_rd(A_TCNT, v); chk("R1", v, 32'h0);

    // R3 words dropped while disabled
    reg_wr(A_TCNT, 32'd100);
    for (int i = 0; i < 3; i++) push(WIDTH'(32'h50 + i), 1'b0);
    repeat (4) @(negedge clk_i);
    reg_rd(A_WPTR, v); chk("R3", v, 32'd0);
    reg_rd(A_STAT, v); chk("R3", v, 32'h8);
    reg_wr(A_CTRL, 32'd1);
    for (int i = 0; i < 2; i++) push(WIDTH'(32'h60 + i), 1'b0);
    repeat (4) @(negedge clk_i);
    reg_rd(A_WPTR, v); chk("R3", v, 32'd2);

    // R4 R5 R6 R7: wrap, trigger at word 20, ignored trigger at 22, budget 4
    do_reset();
    reg_wr(A_TCNT, 32'd4);
    reg_wr(A_WPTR, 32'd0);
    reg_wr(A_CTRL, 32'd1);
    for (int i = 0; i < 30; i++) push(WIDTH'(32'h100 + i), (i == 20) || (i == 22));
    reg_rd(A_STAT, v); chk("R7", v, 32'h7);
    repeat (4) @(negedge clk_i);
    reg_rd(A_STAT, v); chk("R4 R5 R6", v, 32'hF);
    reg_rd(A_WPTR, v); chk("R6", v, 32'd9);
    reg_rd(A_TCNT, v); chk("R6", v, 32'd0);
    reg_wr(A_RPTR, 32'd9);
    for (int k = 0; k < 16; k++) begin
      reg_rd(A_DATA, v); chk("R8", v, 32'h100 + 32'(9 + k));
    end
    reg_rd(A_RPTR, v); chk("R8", v, 32'd9);

    // R10 restart clears flags, keeps pointers
    reg_wr(A_CTRL, 32'd0);
    reg_wr(A_CTRL, 32'd1);
    reg_rd(A_STAT, v); chk("R10", v, 32'h8);
    reg_rd(A_WPTR, v); chk("R10", v, 32'd9);

    // R9 R4: pointer override near ring end
    do_reset();
    reg_wr(A_CTRL, 32'd1);
    reg_wr(A_TCNT, 32'd50);
    reg_wr(A_WPTR, 32'd14);
    reg_rd(A_WPTR, v); chk("R9", v, 32'd14);
    for (int i = 0; i < 3; i++) push(WIDTH'(32'h200 + i), 1'b0);
    repeat (4) @(negedge clk_i);
    reg_rd(A_WPTR, v); chk("R4", v, 32'd1);
    reg_rd(A_STAT, v); chk("R4", v, 32'h9);
    reg_rd(A_TCNT, v); chk("R9", v, 32'd50);
    reg_wr(A_RPTR, 32'd15);
    reg_rd(A_RPTR, v); chk("R9", v, 32'd15);
    reg_rd(A_DATA, v); chk("R8", v, 32'h201);
    reg_rd(A_RPTR, v); chk("R8", v, 32'd0);
    reg_rd(A_DATA, v); chk("R8", v, 32'h202);
    reg_wr(A_RPTR, 32'd14);
    reg_rd(A_DATA, v); chk("R8", v, 32'h200);

    finish_run();
  end
endmodule